// File: doc/BRIEF.md
# External Bus Hand-Over Controller

This block decides who drives the external memory bus: the on-chip CPU or an outside master such as a DMA engine. The outside master asks for the bus by pulling an active-low request line. The controller registers that request and waits for the CPU's current external cycle to finish, including any wait-state extension. It then switches off every output driver of the external bus and pulls an active-low acknowledge line. While the grant holds, it also refuses to let the CPU begin a new external cycle.

When the request line returns high, the controller hands the bus back. It raises the acknowledge line and turns the drivers on again on the same clock edge. It lets the CPU start cycles again one clock after that. The driver enables come out as per-bit vectors for four pin groups:
- the multiplexed address/data lines;
- the upper address lines;
- the read/write/high-write/direction/row-strobe lines;
- the chip selects.

A separate enable gates the address-latch strobe. The internal memory stays reachable only from the CPU, because the block gives the outside master no path into it.

Top module: `bus_grant_ctrl`

## Requirements
- R1: After reset, `busak_n` is 1, every bit of the four driver-enable vectors is 1, `ale_en` is 1 and `cyc_allow` is 1.
- R2: `busrq_n` passes through one register before the controller acts on it. With the bus idle (`cyc_busy`=0, `wait_n`=1), `busak_n` goes to 0 on the second rising clock edge after `busrq_n` goes low, and stays 1 on the first.
- R3: The bus is never granted while `cyc_busy` is 1. `busak_n` stays 1 until `cyc_busy` is seen at 0 on a rising edge with a registered request present.
- R4: The bus is never granted while `wait_n` is 0, even with `cyc_busy` at 0. The grant happens on the first rising edge at which `wait_n` is 1 and `cyc_busy` is 0.
- R5: Whenever `busak_n` is 0, all bits of `ad_oe`, `addr_oe`, `strb_oe` and `cs_oe` are 0 and `ale_en` is 0. These change on the same edge as `busak_n`.
- R6: `cyc_allow` is 0 whenever a registered request is present or the bus is granted.
- R7: `busak_n` returns to 1 on the second rising edge after `busrq_n` goes high (one register, then the state). All driver enables return to 1 on that same edge.
- R8: `cyc_allow` stays 0 on the edge where `busak_n` rises and returns to 1 one clock later if no new request is registered.
- R9: A request withdrawn before the grant is given produces no acknowledge pulse, and CPU cycles are allowed again once the withdrawal is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busrq_n | input | 1 | Active-low bus request from the outside master |
| wait_n | input | 1 | Active-low wait-state extension of the current cycle |
| cyc_busy | input | 1 | CPU external cycle in progress |
| busak_n | output | 1 | Active-low acknowledge: bus drivers are off |
| cyc_allow | output | 1 | CPU may start a new external cycle |
| ad_oe | output | AD_W | Driver enables, multiplexed address/data lines |
| addr_oe | output | ADDR_W | Driver enables, address lines |
| strb_oe | output | STRB_N | Driver enables, strobe and direction lines |
| cs_oe | output | CS_N | Driver enables, chip selects |
| ale_en | output | 1 | Address-latch strobe allowed (0 forces it inactive) |

## Verification
Suppose the hand-over state is wrong. If it jumps to the grant too early, the acknowledge falls while `cyc_busy` or a wait state is still present. That shows at the ports on that very edge. If it gets stuck in the draining or returning phase, `cyc_allow` stays 0 one clock longer than the registered request allows. The reference model compares acknowledge, all driver enables and `cyc_allow` every cycle, so any such slip is reported in the cycle it happens. Directed cases cover a busy CPU, a wait-extended cycle, a withdrawn request and back-to-back requests.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  typedef enum logic [1:0] {
    BG_CPU    = 2'd0,
    BG_DRAIN  = 2'd1,
    BG_HELD   = 2'd2,
    BG_RETURN = 2'd3
  } bg_state_e;

  // The bus may change hands only when no cycle runs and no wait stretches it.
  function automatic logic bus_quiet(input logic busy, input logic wait_n);
    return (!busy) && wait_n;
  endfunction

endpackage

// File: rtl/bgc_rq_sync.sv
module bgc_rq_sync #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_out
);
  logic [DEPTH-1:0] stage;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= req_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= 1'b0;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign req_out = stage[DEPTH-1];
endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
  import bgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rq_s,
  input  logic cyc_busy,
  input  logic wait_n,
  output logic granted,
  output logic allow
);
  bg_state_e state, state_nx;
  logic      quiet;

  assign quiet = bus_quiet(cyc_busy, wait_n);

  always_comb begin
    state_nx = state;
    unique case (state)
      BG_CPU:    if (rq_s) state_nx = quiet ? BG_HELD : BG_DRAIN;
      BG_DRAIN:  if (!rq_s) state_nx = BG_CPU;
                 else if (quiet) state_nx = BG_HELD;
      BG_HELD:   if (!rq_s) state_nx = BG_RETURN;
      BG_RETURN: state_nx = BG_CPU;
      default:   state_nx = BG_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BG_CPU;
    else        state <= state_nx;
  end

  assign granted = (state == BG_HELD);
  assign allow   = (state == BG_CPU) && !rq_s;

  // R3 / R4: a grant only follows an edge where the bus was quiet
  a_r3_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(!cyc_busy));
  a_r4_no_grant_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(wait_n));
  // R6: no new CPU cycle while the request is pending or granted
  a_r6_hold_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_s || granted) |-> !allow);
  // R7: release only follows a withdrawn registered request
  a_r7_release_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(granted) |-> $past(!rq_s));
  // R8: no CPU cycle on the hand-back edge
  a_r8_resume_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(granted) |-> !allow);
endmodule

// File: rtl/bgc_oe_fan.sv
module bgc_oe_fan #(
  parameter int W = 8
) (
  input  logic         drive,
  output logic [W-1:0] oe
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign oe[b] = drive;
    end
  endgenerate
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl #(
  parameter int AD_W       = 16,
  parameter int ADDR_W     = 24,
  parameter int STRB_N     = 5,
  parameter int CS_N       = 3,
  parameter int SYNC_DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busrq_n,
  input  logic              wait_n,
  input  logic              cyc_busy,
  output logic              busak_n,
  output logic              cyc_allow,
  output logic [AD_W-1:0]   ad_oe,
  output logic [ADDR_W-1:0] addr_oe,
  output logic [STRB_N-1:0] strb_oe,
  output logic [CS_N-1:0]   cs_oe,
  output logic              ale_en
);
  logic rq_s;
  logic granted;
  logic drive;

  bgc_rq_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_in(!busrq_n), .req_out(rq_s)
  );

  bgc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rq_s(rq_s), .cyc_busy(cyc_busy),
    .wait_n(wait_n), .granted(granted), .allow(cyc_allow)
  );

  assign drive   = !granted;
  assign busak_n = !granted;
  assign ale_en  = drive;

  bgc_oe_fan #(.W(AD_W))   u_fan_ad   (.drive(drive), .oe(ad_oe));
  bgc_oe_fan #(.W(ADDR_W)) u_fan_addr (.drive(drive), .oe(addr_oe));
  bgc_oe_fan #(.W(STRB_N)) u_fan_strb (.drive(drive), .oe(strb_oe));
  bgc_oe_fan #(.W(CS_N))   u_fan_cs   (.drive(drive), .oe(cs_oe));

  // R5: drivers off whenever the acknowledge is low
  a_r5_float_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !busak_n |-> (ad_oe == '0 && addr_oe == '0 && strb_oe == '0 && cs_oe == '0 && !ale_en));
  // R5: drivers back on whenever the acknowledge is high
  a_r5_drive_off_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busak_n |-> (&ad_oe && &addr_oe && &strb_oe && &cs_oe && ale_en));
  // R2: the acknowledge never falls without a registered request
  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busak_n) |-> $past(rq_s));
endmodule

// File: tb/bus_grant_ctrl_tb.sv
`timescale 1ns/100ps
module bus_grant_ctrl_tb;
  localparam int AD_W = 16, ADDR_W = 24, STRB_N = 5, CS_N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busrq_n = 1'b1, wait_n = 1'b1, cyc_busy = 1'b0;
  logic busak_n, cyc_allow, ale_en;
  logic [AD_W-1:0]   ad_oe;
  logic [ADDR_W-1:0] addr_oe;
  logic [STRB_N-1:0] strb_oe;
  logic [CS_N-1:0]   cs_oe;

  int n_vec = 0;
  int n_bad = 0;

  // model: 0 cpu owns, 1 draining, 2 held by outside master, 3 handing back
  int  m_mode = 0;
  bit  m_req  = 0;

  always #2.5 clk = ~clk;

  bus_grant_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .busrq_n(busrq_n), .wait_n(wait_n),
    .cyc_busy(cyc_busy), .busak_n(busak_n), .cyc_allow(cyc_allow),
    .ad_oe(ad_oe), .addr_oe(addr_oe), .strb_oe(strb_oe), .cs_oe(cs_oe),
    .ale_en(ale_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit quiet;
    quiet = !cyc_busy && wait_n;
    case (m_mode)
      0: if (m_req) m_mode = quiet ? 2 : 1;
      1: if (!m_req) m_mode = 0; else if (quiet) m_mode = 2;
      2: if (!m_req) m_mode = 3;
      default: m_mode = 0;
    endcase
    m_req = !busrq_n;
  endtask

  task automatic compare_all();
    bit held;
    held = (m_mode == 2);
    chk("R2 busak_n", busak_n, !held);
    chk("R5 ad_oe", ad_oe == {AD_W{!held}}, 1'b1);
    chk("R5 addr_oe", addr_oe == {ADDR_W{!held}}, 1'b1);
    chk("R5 strb_oe", strb_oe == {STRB_N{!held}}, 1'b1);
    chk("R5 cs_oe", cs_oe == {CS_N{!held}}, 1'b1);
    chk("R5 ale_en", ale_en, !held);
    chk("R6 cyc_allow", cyc_allow, (m_mode == 0) && !m_req);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busak_n", busak_n, 1'b1);
    chk("R1 oe", &{ad_oe, addr_oe, strb_oe, cs_oe}, 1'b1);
    chk("R1 ale_en", ale_en, 1'b1);
    chk("R1 cyc_allow", cyc_allow, 1'b1);
    rst_n = 1'b1;
    step();

    // R2: idle bus, grant on second edge
    busrq_n = 1'b0;
    step(); chk("R2 no ack first edge", busak_n, 1'b1);
    step(); chk("R2 ack second edge", busak_n, 1'b0);
    chk("R5 all off", |{ad_oe, addr_oe, strb_oe, cs_oe, ale_en}, 1'b0);
    step(); step();
    // R7 / R8: hand back
    busrq_n = 1'b1;
    step(); chk("R7 still held", busak_n, 1'b0);
    step(); chk("R7 ack released", busak_n, 1'b1);
    chk("R7 drivers on", &{ad_oe, addr_oe, strb_oe, cs_oe}, 1'b1);
    chk("R8 gap cycle", cyc_allow, 1'b0);
    step(); chk("R8 cpu resumes", cyc_allow, 1'b1);

    // R3: busy CPU cycle defers grant
    cyc_busy = 1'b1; busrq_n = 1'b0;
    repeat (4) begin step(); chk("R3 busy defers", busak_n, 1'b1); end
    chk("R6 blocked while pending", cyc_allow, 1'b0);
    cyc_busy = 1'b0;
    step(); chk("R3 grant after busy", busak_n, 1'b0);
    busrq_n = 1'b1; step(); step(); step();

    // R4: wait state defers grant
    wait_n = 1'b0; busrq_n = 1'b0;
    repeat (4) begin step(); chk("R4 wait defers", busak_n, 1'b1); end
    wait_n = 1'b1;
    step(); chk("R4 grant after wait", busak_n, 1'b0);
    busrq_n = 1'b1; step(); step(); step();

    // R9: withdrawn request
    cyc_busy = 1'b1; busrq_n = 1'b0;
    step(); step();
    busrq_n = 1'b1;
    step(); chk("R9 no ack", busak_n, 1'b1);
    cyc_busy = 1'b0;
    step(); chk("R9 no ack later", busak_n, 1'b1);
    chk("R9 cpu allowed", cyc_allow, 1'b1);

    // back-to-back requests with mixed conditions
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 8;
      busrq_n  = (r < 3) ? ~busrq_n : busrq_n;
      cyc_busy = ($urandom % 4) == 0;
      wait_n   = ($urandom % 5) != 0;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule